// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block loads a configuration image into a downstream programmable device through that device's passive serial port. A producer streams image bytes over a valid/ready handshake. The loader turns them into a mode-3 serial stream made of a clock, a data line and an active-low select. Around the stream it runs the timed steps the target needs. It holds the select low and waits a setup time. It then pulses the target's active-low reset and waits a quiet time before the first data bit. After the last byte it clocks out a tail of zero bytes and only then raises the select. Finally it waits for the target's done indication, bounded by a timeout, and then waits a settling time before it reports success.

All waits are counted in core clock cycles. The counts are derived from a clock-frequency parameter and from microsecond parameters, rounded up. The serial bit rate comes from a clock-divider parameter. A parameter states whether the done line is wired. When it is not, the loader goes straight from releasing the select to the settling wait. A request for partial reconfiguration is refused at start with an error code, and nothing else happens.

Top module: `pscfg_loader`

## Requirements
- R1: The serial clock idles high. MOSI changes only in a cycle where the serial clock falls, and the target samples MOSI on each rising edge (SPI mode 3).
- R2: While and after `rst_n` is low, with no start since then: `cs_n` = 0, `creset_n` = 0, `sclk` = 1, and `busy`, `ok`, `err` and `s_ready` are all 0.
- R3: An accepted start drives `cs_n` low. `creset_n` is then driven low no sooner than the setup count (CS_SETUP_US) after the start, and stays low for at least the reset count (RST_US). `cs_n` is low whenever `creset_n` is low or changes.
- R4: The first falling edge of `sclk` comes at least the quiet count (PRE_US) after `creset_n` rises.
- R5: Bytes are taken only while the loader is shifting (`s_ready` high, with a transfer on `s_valid && s_ready`). Each byte is sent MSB first, bit 7 on the first rising edge. The byte taken with `s_last` = 1 is the final data byte.
- R6: After the final data byte there are exactly 104 further rising edges of `sclk` (13 zero bytes), all with MOSI low and `cs_n` low.
- R7: `cs_n` rises only after the last trailing rising edge, and `sclk` never rises while `cs_n` is high.
- R8: With the done line wired, if `done_in` has not gone high within the timeout count (TIMEOUT_US) after `cs_n` rises, the loader ends with `err` = 1, `err_code` = 2 and `ok` = 0. `ok` and `err` are never high together.
- R9: Once `done_in` is seen high, the loader waits at least the settling count (USER_US) and then ends with `ok` = 1, `err` = 0 and `err_code` = 0.
- R10: A start with `partial_req` = 1 while idle ends, one cycle later, with `err` = 1, `err_code` = 1 and `busy` = 0. `cs_n`, `creset_n` and `sclk` do not change and no byte is taken. The next plain start clears the error.
- R11: A start while `busy` is high is ignored, so the running load gives exactly one reset pulse.
- R12: With DONE_PRESENT = 0 the loader ignores `done_in` and sets `ok` after the settling count that follows the rise of `cs_n`, with no timeout wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (sampled while idle) |
| partial_req | input | 1 | Marks the start as a partial-reconfiguration request (refused) |
| s_data | input | 8 | Image byte |
| s_valid | input | 1 | Image byte valid |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Loader accepts a byte this cycle |
| sclk | output | 1 | Serial clock to the target, idles high |
| mosi | output | 1 | Serial data to the target |
| cs_n | output | 1 | Active-low select to the target |
| creset_n | output | 1 | Active-low reset to the target |
| done_in | input | 1 | Target's done indication (asynchronous) |
| busy | output | 1 | A load is in progress |
| ok | output | 1 | Last load finished successfully |
| err | output | 1 | Last load or request failed |
| err_code | output | 2 | 0 none, 1 refused request, 2 done timeout |

## Verification
The bench goes after the edges of the serial stream. The count of rising clocks under select must equal eight per byte plus 104. A design that cut the tail short or raised the select early shows a wrong count, or a clock edge with the select released. It also checks every captured bit against the bytes sent, MSB first. Bytes of all ones and all zeros catch a reversed or stuck bit order. Each timed gap is measured at the pins against its rounded-up cycle count, so a delay that is off by its whole length, or skipped, shows up as a short gap. The refused partial request, a second start during a load (which would give a second reset pulse), a done that never arrives (timeout window and code) and the variant without a done line (which must not sit through the timeout) are each run on their own.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CS_SETUP,
    ST_RST,
    ST_PRE,
    ST_SHIFT,
    ST_TRAIL,
    ST_POLL,
    ST_USER
  } state_t;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_INVALID = 2'd1,
    ERR_TIMEOUT = 2'd2
  } err_t;

  localparam int TRAIL_BYTES = 13;

  // Microseconds to core cycles, rounded up, never below one cycle.
  function automatic longint us_to_cycles(longint us, longint hz);
    longint c;
    c = (us * hz + 64'd999_999) / 64'd1_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction

  function automatic longint max_of(longint a, longint b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pscfg_sync2.sv
module pscfg_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  assign dout = s2_q;
endmodule

// File: rtl/pscfg_delay.sv
module pscfg_delay #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= len;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pscfg_shifter.sv
module pscfg_shifter #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  output logic       sclk,
  output logic       mosi,
  output logic       idle,
  output logic       rise_evt
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_M1 = DW'(DIV - 1);

  logic [7:0]    sh_q;
  logic [3:0]    left_q;
  logic [DW-1:0] div_q;
  logic          sclk_q;
  logic          mosi_q;

  assign idle     = (left_q == 4'd0);
  assign rise_evt = !idle && !sclk_q && (div_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      div_q  <= '0;
      sclk_q <= 1'b1;
      mosi_q <= 1'b0;
    end else if (load && idle) begin
      sh_q   <= din;
      left_q <= 4'd8;
      div_q  <= DIV_M1;
      sclk_q <= 1'b0;
      mosi_q <= din[7];
    end else if (!idle) begin
      if (div_q != '0) begin
        div_q <= div_q - 1'b1;
      end else begin
        div_q <= DIV_M1;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else if (left_q == 4'd1) begin
          left_q <= 4'd0;
        end else begin
          left_q <= left_q - 1'b1;
          sh_q   <= {sh_q[6:0], 1'b0};
          mosi_q <= sh_q[6];
          sclk_q <= 1'b0;
        end
      end
    end
  end

  assign sclk = sclk_q;
  assign mosi = mosi_q;
endmodule

// File: rtl/pscfg_loader.sv
module pscfg_loader
  import pscfg_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int SCLK_DIV     = 4,
  parameter bit DONE_PRESENT = 1'b1,
  parameter int CS_SETUP_US  = 10,
  parameter int RST_US       = 10,
  parameter int PRE_US       = 100,
  parameter int USER_US      = 75,
  parameter int TIMEOUT_US   = 100_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       partial_req,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n,
  output logic       creset_n,
  input  logic       done_in,
  output logic       busy,
  output logic       ok,
  output logic       err,
  output logic [1:0] err_code
);
  localparam longint C_SETUP = us_to_cycles(CS_SETUP_US, CLK_HZ);
  localparam longint C_RST   = us_to_cycles(RST_US, CLK_HZ);
  localparam longint C_PRE   = us_to_cycles(PRE_US, CLK_HZ);
  localparam longint C_USER  = us_to_cycles(USER_US, CLK_HZ);
  localparam longint C_TO    = us_to_cycles(TIMEOUT_US, CLK_HZ);
  localparam longint C_MAX   = max_of(max_of(max_of(C_SETUP, C_RST), max_of(C_PRE, C_USER)), C_TO);
  localparam int     TW      = $clog2(C_MAX + 1);
  localparam int     TRW     = $clog2(TRAIL_BYTES + 1);

  localparam logic [TW-1:0]  L_SETUP = TW'(C_SETUP);
  localparam logic [TW-1:0]  L_RST   = TW'(C_RST);
  localparam logic [TW-1:0]  L_PRE   = TW'(C_PRE);
  localparam logic [TW-1:0]  L_USER  = TW'(C_USER);
  localparam logic [TW-1:0]  L_TO    = TW'(C_TO);
  localparam logic [TRW-1:0] L_TRAIL = TRW'(TRAIL_BYTES);

  state_t         st_q, st_n;
  logic           cs_q, cs_d;
  logic           cre_q, cre_d;
  logic           ok_q, ok_d;
  logic           err_q, err_d;
  err_t           code_q, code_d;
  logic [TRW-1:0] trail_q, trail_d;
  logic           last_q, last_d;

  logic           t_load;
  logic [TW-1:0]  t_len;
  logic           t_exp;
  logic           sh_load;
  logic [7:0]     sh_byte;
  logic           sh_idle;
  logic           sh_rise;
  logic           done_s;

  // Named events for the checker.
  logic ev_reject;
  logic in_trail;

  pscfg_delay #(.W(TW)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .expired(t_exp)
  );

  pscfg_shifter #(.DIV(SCLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .din(sh_byte),
    .sclk(sclk), .mosi(mosi), .idle(sh_idle), .rise_evt(sh_rise)
  );

  pscfg_sync2 u_done_sync (
    .clk(clk), .rst_n(rst_n), .din(done_in), .dout(done_s)
  );

  assign s_ready   = (st_q == ST_SHIFT) && sh_idle && !last_q;
  assign ev_reject = (st_q == ST_IDLE) && start && partial_req;
  assign in_trail  = (st_q == ST_TRAIL);

  always_comb begin
    st_n    = st_q;
    cs_d    = cs_q;
    cre_d   = cre_q;
    ok_d    = ok_q;
    err_d   = err_q;
    code_d  = code_q;
    trail_d = trail_q;
    last_d  = last_q;
    t_load  = 1'b0;
    t_len   = '0;
    sh_load = 1'b0;
    sh_byte = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start && partial_req) begin
          ok_d   = 1'b0;
          err_d  = 1'b1;
          code_d = ERR_INVALID;
        end else if (start) begin
          ok_d   = 1'b0;
          err_d  = 1'b0;
          code_d = ERR_NONE;
          cs_d   = 1'b0;
          last_d = 1'b0;
          st_n   = ST_CS_SETUP;
          t_load = 1'b1;
          t_len  = L_SETUP;
        end
      end
      ST_CS_SETUP: if (t_exp) begin
        cre_d  = 1'b0;
        st_n   = ST_RST;
        t_load = 1'b1;
        t_len  = L_RST;
      end
      ST_RST: if (t_exp) begin
        cre_d  = 1'b1;
        st_n   = ST_PRE;
        t_load = 1'b1;
        t_len  = L_PRE;
      end
      ST_PRE: if (t_exp) begin
        st_n = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (last_q) begin
          if (sh_idle) begin
            st_n    = ST_TRAIL;
            trail_d = L_TRAIL;
          end
        end else if (s_ready && s_valid) begin
          sh_load = 1'b1;
          sh_byte = s_data;
          last_d  = s_last;
        end
      end
      ST_TRAIL: if (sh_idle) begin
        if (trail_q != '0) begin
          sh_load = 1'b1;
          trail_d = trail_q - 1'b1;
        end else begin
          cs_d   = 1'b1;
          t_load = 1'b1;
          if (DONE_PRESENT) begin
            st_n  = ST_POLL;
            t_len = L_TO;
          end else begin
            st_n  = ST_USER;
            t_len = L_USER;
          end
        end
      end
      ST_POLL: begin
        if (done_s) begin
          st_n   = ST_USER;
          t_load = 1'b1;
          t_len  = L_USER;
        end else if (t_exp) begin
          err_d  = 1'b1;
          code_d = ERR_TIMEOUT;
          st_n   = ST_IDLE;
        end
      end
      ST_USER: if (t_exp) begin
        ok_d = 1'b1;
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cs_q    <= 1'b0;
      cre_q   <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= ERR_NONE;
      trail_q <= '0;
      last_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      cs_q    <= cs_d;
      cre_q   <= cre_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
      code_q  <= code_d;
      trail_q <= trail_d;
      last_q  <= last_d;
    end
  end

  assign cs_n     = cs_q;
  assign creset_n = cre_q;
  assign busy     = (st_q != ST_IDLE);
  assign ok       = ok_q;
  assign err      = err_q;
  assign err_code = code_q;
endmodule

module pscfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       mosi,
  input logic       cs_n,
  input logic       creset_n,
  input logic       s_ready,
  input logic       busy,
  input logic       ok,
  input logic       err,
  input logic [1:0] err_code,
  input logic       ev_reject,
  input logic       in_trail,
  input logic       sh_rise
);
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R1
  AST_RISE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sh_rise |-> !cs_n); // R7
  AST_SCLK_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk); // R7
  AST_RESET_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !creset_n |-> !cs_n); // R3
  AST_TRAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_trail && !sclk) |-> !mosi); // R6
  AST_READY_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && !cs_n && creset_n)); // R5
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (!busy && err && err_code == 2'd1 && $stable(cs_n) && $stable(creset_n))); // R10
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && err)); // R8
endmodule

bind pscfg_loader pscfg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
  .creset_n(creset_n), .s_ready(s_ready), .busy(busy), .ok(ok), .err(err),
  .err_code(err_code), .ev_reject(ev_reject), .in_trail(in_trail),
  .sh_rise(sh_rise)
);

// File: tb/test_pscfg_loader.sv
module test_pscfg_loader;
  localparam int HZ  = 10_000_000;
  localparam int DIV = 2;
  localparam int TO_US = 200;

  function automatic int cy(int us);
    return int'((longint'(us) * HZ + 999_999) / 1_000_000);
  endfunction

  localparam int E_SETUP = 100;  // 10 us
  localparam int E_RST   = 100;  // 10 us
  localparam int E_PRE   = 1000; // 100 us
  localparam int E_USER  = 750;  // 75 us

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, partial = 0, s_valid = 0, s_last = 0, done_in = 0;
  logic [7:0] s_data = '0;
  logic s_ready, sclk, mosi, cs_n, cre_n, busy, ok, err;
  logic [1:0] code;

  logic n_start = 0, n_valid = 0, n_last = 0, n_done = 0;
  logic [7:0] n_data = '0;
  logic n_ready, n_sclk, n_mosi, n_cs, n_cre, n_busy, n_ok, n_err;
  logic [1:0] n_code;

  always #5 clk = ~clk;

  pscfg_loader #(.CLK_HZ(HZ), .SCLK_DIV(DIV), .DONE_PRESENT(1'b1), .TIMEOUT_US(TO_US)) i_pscfg_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .partial_req(partial), .s_data(s_data),
    .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .creset_n(cre_n), .done_in(done_in), .busy(busy), .ok(ok), .err(err),
    .err_code(code));

  pscfg_loader #(.CLK_HZ(HZ), .SCLK_DIV(DIV), .DONE_PRESENT(1'b0), .TIMEOUT_US(TO_US)) i_pscfg_loader_nodone (
    .clk(clk), .rst_n(rst_n), .start(n_start), .partial_req(1'b0), .s_data(n_data),
    .s_valid(n_valid), .s_last(n_last), .s_ready(n_ready), .sclk(n_sclk), .mosi(n_mosi),
    .cs_n(n_cs), .creset_n(n_cre), .done_in(n_done), .busy(n_busy), .ok(n_ok), .err(n_err),
    .err_code(n_code));

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(bit good, string req, string what, longint act, longint exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor, main instance (sampled at negedge).
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic bits [0:4095];
  int nbits = 0, rises_nocs = 0, cre_falls = 0, cs_bad = 0, ready_seen = 0;
  int t_cre_fall = 0, t_cre_rise = 0, t_ff = 0, t_cs_rise = 0, t_last_rise = 0;
  int t_ok = 0, t_err = 0, t_done = 0;
  bit pend_ff = 0;
  logic p_sclk = 1, p_cs = 0, p_cre = 0, p_ok = 0, p_err = 0, p_done = 0;

  always @(negedge clk) if (rst_n) begin
    if (sclk && !p_sclk) begin
      if (!cs_n) begin
        if (nbits < 4096) bits[nbits] = mosi;
        nbits++;
        t_last_rise = cyc;
      end else rises_nocs++;
    end
    if (!sclk && p_sclk && pend_ff) begin t_ff = cyc; pend_ff = 0; end
    if (!cre_n && p_cre) begin t_cre_fall = cyc; cre_falls++; if (cs_n) cs_bad++; end
    if (cre_n && !p_cre) begin t_cre_rise = cyc; pend_ff = 1; if (cs_n) cs_bad++; end
    if (cs_n && !p_cs) t_cs_rise = cyc;
    if (ok && !p_ok) t_ok = cyc;
    if (err && !p_err) t_err = cyc;
    if (done_in && !p_done) t_done = cyc;
    if (s_ready) ready_seen++;
    p_sclk = sclk; p_cs = cs_n; p_cre = cre_n; p_ok = ok; p_err = err; p_done = done_in;
  end

  // Monitor, instance without done line.
  int n_rises = 0, n_t_cs = 0, n_t_ok = 0;
  logic np_sclk = 1, np_cs = 0, np_ok = 0;
  always @(negedge clk) if (rst_n) begin
    if (n_sclk && !np_sclk && !n_cs) n_rises++;
    if (n_cs && !np_cs) n_t_cs = cyc;
    if (n_ok && !np_ok) n_t_ok = cyc;
    np_sclk = n_sclk; np_cs = n_cs; np_ok = n_ok;
  end

  function automatic logic [7:0] pat(int i, int seed);
    if (seed == 3) return (i % 2 == 0) ? 8'hFF : 8'h00;
    return 8'((i * 37 + seed * 11 + 90) & 255);
  endfunction

  task automatic do_load(int n, int seed, bit give_done, int dly, bit restart, bit first);
    int b0, f0, t_start, bad_data, bad_tail;
    b0 = nbits;
    f0 = cre_falls;
    done_in = 0;
    @(negedge clk);
    start = 1; t_start = cyc + 1;
    @(negedge clk);
    start = 0;
    fork
      begin
        for (int idx = 0; idx < n; ) begin
          @(negedge clk);
          s_valid = 1; s_data = pat(idx, seed); s_last = (idx == n - 1);
          if (s_ready) idx++;
        end
        @(negedge clk);
        s_valid = 0; s_last = 0;
      end
      if (give_done) begin
        @(posedge cs_n);
        repeat (dly) @(negedge clk);
        done_in = 1;
      end
      if (restart) begin
        @(posedge cre_n);
        repeat (20) @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
      end
    join
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);

    bad_data = 0;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++)
        if (bits[b0 + 8 * i + k] !== pat(i, seed)[7 - k]) bad_data++;
    bad_tail = 0;
    for (int j = 0; j < 104; j++)
      if (bits[b0 + 8 * n + j] !== 1'b0) bad_tail++;

    chk(nbits - b0 == 8 * n + 104, "R1", "rising edges under select", nbits - b0, 8 * n + 104);
    chk(bad_data == 0, "R5", "data bits MSB first mismatches", bad_data, 0);
    chk(bad_tail == 0, "R6", "trailing clocks with MOSI high", bad_tail, 0);
    chk(rises_nocs == 0 && t_cs_rise > t_last_rise, "R7", "select release after last clock",
        t_cs_rise - t_last_rise, 1);
    chk(cs_bad == 0, "R3", "reset edges with select released", cs_bad, 0);
    if (first) begin
      chk(t_cre_rise - t_start >= E_SETUP + E_RST, "R3", "start to reset release",
          t_cre_rise - t_start, E_SETUP + E_RST);
    end else begin
      chk(t_cre_fall - t_start >= E_SETUP, "R3", "select setup before reset",
          t_cre_fall - t_start, E_SETUP);
      chk(t_cre_rise - t_cre_fall >= E_RST, "R3", "reset pulse width",
          t_cre_rise - t_cre_fall, E_RST);
    end
    chk(cre_falls - f0 == (first ? 0 : 1), "R11", "reset pulses this load",
        cre_falls - f0, first ? 0 : 1);
    chk(t_ff - t_cre_rise >= E_PRE, "R4", "reset release to first clock",
        t_ff - t_cre_rise, E_PRE);
    if (give_done) begin
      chk(ok && !err && code == 2'd0, "R9", "success status", {ok, err, code}, 4'b1000);
      chk(t_ok - t_done >= E_USER, "R9", "done to success gap", t_ok - t_done, E_USER);
    end else begin
      chk(err && !ok && code == 2'd2, "R8", "timeout status", {ok, err, code}, 4'b0110);
      chk(t_err - t_cs_rise >= cy(TO_US) && t_err - t_cs_rise <= cy(TO_US) + 4, "R8",
          "timeout window", t_err - t_cs_rise, cy(TO_US));
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(cs_n == 0 && cre_n == 0 && sclk == 1, "R2", "pins in reset", {cs_n, cre_n, sclk}, 3'b001);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 0 && cre_n == 0 && sclk == 1, "R2", "pins after reset", {cs_n, cre_n, sclk}, 3'b001);
    chk(!busy && !ok && !err && !s_ready, "R2", "status after reset", {busy, ok, err, s_ready}, 0);

    do_load(1, 0, 1, 30, 0, 1);
    do_load(3, 1, 1, 5, 1, 0);    // second start mid-load
    do_load(4, 3, 1, 1500, 0, 0); // 0xFF/0x00 bytes, late done

    // R10: refused partial request
    begin
      logic pc, pr, ps;
      int r0;
      @(negedge clk);
      pc = cs_n; pr = cre_n; ps = sclk; r0 = ready_seen;
      start = 1; partial = 1;
      @(negedge clk);
      start = 0; partial = 0;
      chk(err && code == 2'd1 && !busy && !ok, "R10", "refused status",
          {busy, ok, err, code}, 4'b0011);
      repeat (20) @(negedge clk);
      chk(cs_n == pc && cre_n == pr && sclk == ps && ready_seen == r0, "R10",
          "pins untouched by refused request", {cs_n, cre_n, sclk}, {pc, pr, ps});
    end

    do_load(2, 2, 0, 0, 0, 0);    // no done: timeout
    chk(!err || code == 2'd2, "R8", "error kept after timeout", code, 2);
    do_load(5, 4, 1, 0, 0, 0);    // clears error, done at once
    chk(code == 2'd0, "R10", "plain start clears error", code, 0);

    // R12: no done line
    begin
      int r0;
      r0 = n_rises;
      n_done = 1'b1;
      @(negedge clk);
      n_start = 1;
      @(negedge clk);
      n_start = 0;
      for (int idx = 0; idx < 2; ) begin
        @(negedge clk);
        n_valid = 1; n_data = pat(idx, 5); n_last = (idx == 1);
        if (n_ready) idx++;
      end
      @(negedge clk);
      n_valid = 0; n_last = 0;
      while (n_busy) @(negedge clk);
      @(negedge clk);
      chk(n_ok && !n_err && n_code == 2'd0, "R12", "success without done line",
          {n_ok, n_err, n_code}, 4'b1000);
      chk(n_t_ok - n_t_cs >= E_USER && n_t_ok - n_t_cs <= E_USER + 4, "R12",
          "select release to success gap", n_t_ok - n_t_cs, E_USER);
      chk(n_rises - r0 == 16 + 104, "R12", "rising edges", n_rises - r0, 120);
    end

    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150_000, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule